// File: doc/BRIEF.md
# Three-Digit Sequence Lock

This block watches a stream of decimal digits, one 4-bit binary code per accepted cycle, and raises its open output once the digits 3, 8 and 4 have been accepted back to back. A digit counts only in a cycle where the valid strobe is high. In cycles where the strobe is low, the machine keeps its position in the sequence.

The open output is a Mealy output. It depends on the present position in the sequence and on the digit being presented now. It therefore goes high in the same cycle that the final correct digit is offered, one edge before the machine records that it has opened.

Once open, the lock stays open whatever digits follow. Only a synchronous, active-high reset closes it again. A repeated 3 in the middle of an attempt is not thrown away: it is taken as the first digit of a new attempt.

Top module: `seq_lock`

## Requirements
- R1: A synchronous active-high reset puts the machine in its start position (code 00), even when a valid digit is offered in that same cycle. After the reset edge the output is 0 until a full correct sequence is accepted.
- R2: In the start position (00), an accepted digit 3 (binary 0011) advances the machine to the seen-first position (01). Any other accepted digit leaves it at start. The output stays 0 in both cases.
- R3: In the seen-first position (01), an accepted 8 (1000) advances the machine to seen-second (10). An accepted 3 keeps it in seen-first. Any other accepted digit sends it back to start. The output stays 0 in all three cases.
- R4: In the seen-second position (10), an accepted 4 (0100) moves the machine to open (11), and the output is 1 in that same cycle. An accepted 3 returns it to seen-first and any other accepted digit returns it to start, both with output 0.
- R5: The open position (11) cannot be left except by reset. In it the output is 1 on every cycle, for every digit value and for either level of the valid strobe.
- R6: When the valid strobe is low, the position does not change. The output is then 1 only in the open position; in particular, a 4 presented without the strobe in seen-second gives output 0.
- R7: Input codes 10 to 15 behave as wrong digits. From positions 00, 01 and 10 they return the machine to start. In the open position they are ignored.
- R8: The output is combinational in the present position and the present input. It is 1 exactly when the machine is open, or when it is in seen-second with an accepted 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock; drives only the state register |
| rst | input | 1 | Synchronous active-high reset to the start position |
| digit_vld | input | 1 | High when `digit` carries a digit to be accepted this cycle |
| digit | input | 4 | Binary code of the offered digit |
| unlock | output | 1 | Mealy open output |

## Verification
The sequence function is tried with several input patterns:
- the clean sequence 3, 8, 4;
- sequences broken at each step by a wrong digit;
- sequences broken by a stray 3, which must restart at the second step rather than at start;
- the sequence with idle cycles between digits, and a 4 held without the strobe;
- non-decimal codes 10 to 15 offered at each position;
- a long stream of arbitrary codes after opening.

Each pattern tells a different fault apart:
- the stray-3 runs separate a restart at seen-first from a full clear;
- the idle runs separate a strobe-gated design from one that samples every cycle;
- the held 4 without the strobe exposes a Mealy term that ignores the strobe;
- the reset-with-digit case shows whether reset takes priority.

The reference model predicts the output before every edge, so an output that appears one cycle late is caught as well as a wrong transition.

// File: rtl/seq_lock_pkg.sv
package seq_lock_pkg;

    typedef enum logic [1:0] {
        LK_IDLE = 2'b00,
        LK_GOT1 = 2'b01,
        LK_GOT2 = 2'b10,
        LK_OPEN = 2'b11
    } lock_st_e;

    typedef struct packed {
        lock_st_e st;
    } lock_regs_t;

    localparam lock_regs_t LOCK_RESET = '{st: LK_IDLE};

endpackage

// File: rtl/seq_lock_match.sv
// Compares one offered digit against a fixed code value, qualified by the strobe.
module seq_lock_match #(
    parameter int unsigned DIGIT_W = 4,
    parameter int unsigned VALUE   = 0
) (
    input  logic               vld,
    input  logic [DIGIT_W-1:0] digit,
    output logic               hit
);
    localparam logic [DIGIT_W-1:0] VAL_C = DIGIT_W'(VALUE);

    always_comb begin
        hit = vld && (digit == VAL_C);
    end
endmodule

// File: rtl/seq_lock_next.sv
// Next position of the sequence tracker.
module seq_lock_next
    import seq_lock_pkg::*;
(
    input  lock_st_e   st,
    input  logic       vld,
    input  logic [2:0] hit,   // [0] first code, [1] second code, [2] third code
    output lock_st_e   st_nx
);
    always_comb begin
        st_nx = st;
        if (vld) begin
            unique case (st)
                LK_IDLE: st_nx = hit[0] ? LK_GOT1 : LK_IDLE;
                LK_GOT1: begin
                    if (hit[1])      st_nx = LK_GOT2;
                    else if (hit[0]) st_nx = LK_GOT1;
                    else             st_nx = LK_IDLE;
                end
                LK_GOT2: begin
                    if (hit[2])      st_nx = LK_OPEN;
                    else if (hit[0]) st_nx = LK_GOT1;
                    else             st_nx = LK_IDLE;
                end
                LK_OPEN: st_nx = LK_OPEN;
                default: st_nx = LK_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/seq_lock_out.sv
// Mealy output decode.
module seq_lock_out
    import seq_lock_pkg::*;
(
    input  lock_st_e st,
    input  logic     last_hit,
    output logic     open_o
);
    always_comb begin
        open_o = (st == LK_OPEN) || ((st == LK_GOT2) && last_hit);
    end
endmodule

// File: rtl/seq_lock.sv
module seq_lock
    import seq_lock_pkg::*;
#(
    parameter int unsigned DIGIT_W = 4,
    parameter int unsigned CODE0   = 3,
    parameter int unsigned CODE1   = 8,
    parameter int unsigned CODE2   = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               digit_vld,
    input  logic [DIGIT_W-1:0] digit,
    output logic               unlock
);
    localparam int unsigned N_CODES = 3;
    localparam int unsigned CODES [N_CODES] = '{CODE0, CODE1, CODE2};

    lock_regs_t regs_d, regs_q;
    logic [N_CODES-1:0] hit;
    lock_st_e st_nx;

    for (genvar g = 0; g < N_CODES; g++) begin : g_match
        seq_lock_match #(.DIGIT_W(DIGIT_W), .VALUE(CODES[g])) u_match (
            .vld   (digit_vld),
            .digit (digit),
            .hit   (hit[g])
        );
    end

    seq_lock_next u_next (
        .st    (regs_q.st),
        .vld   (digit_vld),
        .hit   (hit),
        .st_nx (st_nx)
    );

    seq_lock_out u_out (
        .st       (regs_q.st),
        .last_hit (hit[N_CODES-1]),
        .open_o   (unlock)
    );

    always_comb begin
        regs_d    = regs_q;
        regs_d.st = st_nx;
        if (rst) regs_d = LOCK_RESET;
    end

    always_ff @(posedge clk) begin
        regs_q <= regs_d;
    end
endmodule

// File: rtl/seq_lock_chk.sv
module seq_lock_chk
    import seq_lock_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       digit_vld,
    input logic [3:0] digit,
    input logic       unlock,
    input lock_st_e   st
);
    p_reset_start_r1: assert property (@(posedge clk) rst |=> (st == LK_IDLE));

    p_first_adv_r2: assert property (@(posedge clk) disable iff (rst)
        (st == LK_IDLE && digit_vld && digit == 4'd3) |=> (st == LK_GOT1));

    p_stray3_r3: assert property (@(posedge clk) disable iff (rst)
        (st == LK_GOT1 && digit_vld && digit == 4'd3) |=> (st == LK_GOT1));

    p_open_now_r4: assert property (@(posedge clk) disable iff (rst)
        (st == LK_GOT2 && digit_vld && digit == 4'd4) |-> unlock);

    p_absorb_r5: assert property (@(posedge clk) disable iff (rst)
        (st == LK_OPEN) |=> (st == LK_OPEN && unlock));

    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !digit_vld |=> $stable(st));

    p_bad_code_r7: assert property (@(posedge clk) disable iff (rst)
        (digit_vld && digit > 4'd9 && st != LK_OPEN) |=> (st == LK_IDLE));

    p_closed_r8: assert property (@(posedge clk) disable iff (rst)
        (st == LK_IDLE || st == LK_GOT1) |-> !unlock);
endmodule

bind seq_lock seq_lock_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .digit_vld (digit_vld),
    .digit     (digit),
    .unlock    (unlock),
    .st        (regs_q.st)
);

// File: tb/seq_lock_test.sv
module seq_lock_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       digit_vld = 1'b0;
    logic [3:0] digit = 4'd0;
    logic       unlock;

    int checks = 0;
    int failures = 0;
    int mst = 0;      // reference position: 0 start, 1 seen 3, 2 seen 3-8, 3 open
    bit done = 0;

    seq_lock uut (
        .clk       (clk),
        .rst       (rst),
        .digit_vld (digit_vld),
        .digit     (digit),
        .unlock    (unlock)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int model_next(int s, bit v, int d);
        if (!v) return s;
        case (s)
            0: return (d == 3) ? 1 : 0;
            1: return (d == 8) ? 2 : ((d == 3) ? 1 : 0);
            2: return (d == 4) ? 3 : ((d == 3) ? 1 : 0);
            default: return 3;
        endcase
    endfunction

    // one cycle: drive, compare the Mealy output before the edge, update the model
    task automatic step(bit r, bit v, int d, string tag);
        bit exp;
        @(negedge clk);
        rst = r; digit_vld = v; digit = 4'(d);
        #1;
        exp = (mst == 3) || (mst == 2 && v && d == 4);
        checks++;
        if (unlock !== exp) begin
            failures++;
            $display("FAIL %s: unlock actual=%0b expected=%0b (pos=%0d vld=%0b digit=%0d)",
                     tag, unlock, exp, mst, v, d);
        end
        @(posedge clk);
        mst = r ? 0 : model_next(mst, v, d);
    endtask

    task automatic enter(int d, string tag);
        step(0, 1, d, tag);
    endtask

    initial begin
        // reset with a digit present; first check is on the post-reset state
        @(posedge clk);
        @(posedge clk);
        mst = 0;
        step(1, 1, 3, "R1");
        step(0, 0, 0, "R1");
        // R2: wrong digits stay at start, 3 advances
        enter(5, "R2"); enter(0, "R2"); enter(3, "R2");
        // R3: repeated 3 keeps seen-first, then 8
        enter(3, "R3"); enter(3, "R3"); enter(8, "R3");
        // R6: idle cycles and a 4 without strobe
        step(0, 0, 4, "R6"); step(0, 0, 7, "R6");
        // R4: final 4 opens in the same cycle
        enter(4, "R4");
        // R5: absorbing, any input, strobe either level
        for (int i = 0; i < 20; i++) step(0, i % 2, i % 16, "R5");
        // R1: reset overrides a digit, machine closes
        step(1, 1, 4, "R1");
        enter(8, "R1"); enter(4, "R1");
        // R3: wrong digit after 3
        enter(3, "R3"); enter(7, "R3"); enter(8, "R3"); enter(4, "R3");
        // R4: stray 3 after 3-8 restarts at seen-first
        enter(3, "R4"); enter(8, "R4"); enter(3, "R4"); enter(8, "R4");
        // R4: wrong digit after 3-8
        enter(9, "R4"); enter(4, "R4");
        // R7: codes 10..15 at each position
        for (int c = 10; c < 16; c++) begin
            enter(3, "R7"); enter(c, "R7"); enter(8, "R7");
            enter(3, "R7"); enter(8, "R7"); enter(c, "R7"); enter(4, "R7");
        end
        // R8: open via full sequence with idle gaps, then non-digits ignored
        enter(3, "R8"); step(0, 0, 3, "R8"); enter(8, "R8");
        step(0, 0, 4, "R8"); enter(4, "R8");
        for (int c = 10; c < 16; c++) enter(c, "R7");
        step(1, 0, 0, "R1"); step(0, 0, 0, "R1");
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule